// File: doc/BRIEF.md
# Byte-Packing Longword FIFO

This block is a small synchronous FIFO that builds 32-bit longwords from writes of mixed size. A narrow producer, such as an 8-bit peripheral, can push single bytes. A 16-bit source can push half-words, and a wide source can push whole longwords. The consumer on the 32-bit side sees the oldest complete longword on its read bus at all times, with no read-enable latency, and pops it with a one-cycle strobe.

An internal lane pointer tracks where the next byte of the entry being assembled will land. Lanes are numbered big-endian: lane 0 is bits 31:24 and lane 3 is bits 7:0. Per-lane write strobes come from the lane pointer and the transfer size. An entry becomes visible to the reader only once all four lanes are filled, or when a flush forces a partial entry out. The block also reports full and empty, and raises a one-cycle error pulse for a write whose size does not fit the current lane.

Top module: `lw_pack_fifo`

## Requirements
- R1: While `rst_n` is low and right after it is released, `empty` is 1, `full` is 0 and `wr_err` is 0, and the lane pointer starts at lane 0.
- R2: With `wr_size` = 2'b00 (byte), `wr_data[7:0]` goes into the lane under the pointer and the pointer moves on by one lane. Four byte writes from lane 0 produce the entry {b0,b1,b2,b3}, with the first byte in bits 31:24, and that entry becomes readable after the fourth write.
- R3: With `wr_size` = 2'b01 (half-word), `wr_data[15:0]` fills bits 31:16 when the pointer is at lane 0 and bits 15:0 when it is at lane 2. Byte and half-word writes may be mixed within one entry.
- R4: With `wr_size` = 2'b10 (longword) and the pointer at lane 0, `wr_data` becomes one complete entry in a single write.
- R5: A misaligned write changes neither the stored data nor the lane pointer, and it sets `wr_err` for exactly the following cycle. Misaligned writes are a half-word at lane 1 or 3, a longword at any lane but 0, and any write with `wr_size` = 2'b11.
- R6: `rd_data` always shows the oldest complete entry while `empty` is 0. A `pop` moves it to the next entry in the cycle after the pop, and `rd_data` holds still while no pop occurs.
- R7: A `pop` while `empty` is 1 has no effect.
- R8: `full` is 1 when 8 complete entries are held. A write while full is dropped without changing the lane pointer or the contents.
- R9: When the pointer is not at lane 0, `flush` commits the partial entry with its unwritten lanes at zero and returns the pointer to lane 0. At lane 0, `flush` does nothing. A write in the same cycle as `flush` is ignored and raises no error.
- R10: A `pop` and an entry commit in the same cycle both take effect, so the number of entries held stays consistent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_size | input | 2 | Transfer size: 00 byte, 01 half-word, 10 longword, 11 reserved |
| wr_data | input | 32 | Write data, right-justified for byte and half-word transfers |
| flush | input | 1 | Commit the partially filled entry |
| pop | input | 1 | Remove the head entry |
| rd_data | output | 32 | Head entry, driven combinationally |
| full | output | 1 | Eight complete entries held |
| empty | output | 1 | No complete entry held |
| wr_err | output | 1 | One-cycle pulse after a misaligned write |

## Verification
The bench targets the lane arithmetic first: half-words at lanes 1 and 3, longwords at lanes 1 to 3, and the reserved size code. A design that got these wrong would smear data across an entry boundary or move the pointer on an illegal write. It also pushes a write against a full FIFO, pops an empty one, and commits an entry in the same cycle as a pop. A wrong design would overwrite the head, underflow the read pointer, or lose count of entries. A flush after one, two and three lanes, and a flush that collides with a write, catch a design that leaves stale bytes in the unwritten lanes or lets the colliding write through.

// File: rtl/lwf_pkg.sv
package lwf_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } wsize_e;

  // Number of byte lanes a transfer of the given size occupies; 0 = illegal.
  function automatic int size_lanes(wsize_e sz, int lanes);
    case (sz)
      SZ_BYTE: return 1;
      SZ_HALF: return lanes / 2;
      SZ_LONG: return lanes;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/lwf_lane_steer.sv
module lwf_lane_steer
  import lwf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int LANES  = DATA_W / BYTE_W,
  parameter int LW     = $clog2(LANES)
) (
  input  logic [LW-1:0]     bptr,
  input  wsize_e            size,
  input  logic [DATA_W-1:0] din,
  output logic [LANES-1:0]  lane_we,
  output logic [DATA_W-1:0] lane_data,
  output logic              aligned,
  output logic              wrap,
  output logic [LW-1:0]     bptr_next
);

  int span;
  int end_lane;

  always_comb begin
    span     = size_lanes(size, LANES);
    aligned  = (span != 0) && ((int'(bptr) % span) == 0);
    end_lane = int'(bptr) + span;
    wrap     = aligned && (end_lane == LANES);
    bptr_next = LW'(end_lane % LANES);
  end

  // Lane k sits at bits [DATA_W-1-BYTE_W*k -: BYTE_W]; the first lane written
  // receives the most significant byte of the right-justified input.
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic              we_k;
    logic [BYTE_W-1:0] byte_k;

    always_comb begin
      int off;
      int src;
      off    = k - int'(bptr);
      we_k   = aligned && (off >= 0) && (off < span);
      src    = 0;
      byte_k = '0;
      if (we_k) begin
        src    = span - 1 - off;
        byte_k = din[BYTE_W*src +: BYTE_W];
      end
    end

    assign lane_we[k] = we_k;
    assign lane_data[DATA_W-1-BYTE_W*k -: BYTE_W] = byte_k;
  end

endmodule

// File: rtl/lwf_pack_stage.sv
module lwf_pack_stage #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int LANES  = DATA_W / BYTE_W,
  parameter int LW     = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              flush,
  input  logic              full,
  input  logic [LANES-1:0]  lane_we,
  input  logic [DATA_W-1:0] lane_data,
  input  logic              aligned,
  input  logic              wrap,
  input  logic [LW-1:0]     bptr_next,
  output logic [LW-1:0]     bptr,
  output logic              commit,
  output logic [DATA_W-1:0] commit_data,
  output logic              wr_err
);

  logic [DATA_W-1:0] stage_q, stage_d, merged;
  logic [LW-1:0]     bptr_d;
  logic              err_d;
  logic              accept;
  logic              stage_en;

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      merged[DATA_W-1-BYTE_W*k -: BYTE_W] = lane_we[k]
        ? lane_data[DATA_W-1-BYTE_W*k -: BYTE_W]
        : stage_q[DATA_W-1-BYTE_W*k -: BYTE_W];
    end
  end

  always_comb begin
    accept      = wr_en && !flush && aligned && !full;
    err_d       = wr_en && !flush && !aligned;
    commit      = 1'b0;
    commit_data = merged;
    stage_d     = stage_q;
    bptr_d      = bptr;
    if (flush) begin
      commit      = (bptr != '0);
      commit_data = stage_q;
      stage_d     = '0;
      bptr_d      = '0;
    end else if (accept) begin
      commit  = wrap;
      stage_d = wrap ? '0 : merged;
      bptr_d  = bptr_next;
    end
    stage_en = flush || accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      bptr    <= '0;
      wr_err  <= 1'b0;
    end else begin
      wr_err <= err_d;
      if (stage_en) begin
        stage_q <= stage_d;
        bptr    <= bptr_d;
      end
    end
  end

  AST_FLUSH_HOMES_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (bptr == '0)); // R9
  AST_ERR_AFTER_MISALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush && !aligned) |=> wr_err); // R5
  AST_ERR_ONLY_MISALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && !flush && !aligned) |=> !wr_err); // R5
  AST_MISALIGN_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush && !aligned) |=> $stable(bptr)); // R5

endmodule

// File: rtl/lwf_ptr_ctrl.sv
module lwf_ptr_ctrl #(
  parameter int DEPTH = 8,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit,
  input  logic          pop,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic          full,
  output logic          empty
);

  localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CFULL = CW'(DEPTH);

  logic [CW-1:0] count, count_d;
  logic [AW-1:0] wr_ptr_d, rd_ptr_d;
  logic          pop_ok;

  assign full  = (count == CFULL);
  assign empty = (count == '0);

  always_comb begin
    pop_ok   = pop && !empty;
    wr_ptr_d = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
    rd_ptr_d = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
    count_d  = count;
    if (commit && !pop_ok)      count_d = count + 1'b1;
    else if (!commit && pop_ok) count_d = count - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (commit) wr_ptr <= wr_ptr_d;
      if (pop_ok) rd_ptr <= rd_ptr_d;
      if (commit != pop_ok) count <= count_d;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CFULL); // R8
  AST_NO_COMMIT_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !commit); // R8
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full); // R8
  AST_EMPTY_POP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !commit) |=> (empty && $stable(rd_ptr))); // R7
  AST_POP_AND_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && pop && !empty) |=> $stable(count)); // R10

endmodule

// File: rtl/lwf_entry_store.sv
module lwf_entry_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              commit,
  input  logic [AW-1:0]     wr_ptr,
  input  logic [DATA_W-1:0] commit_data,
  input  logic [AW-1:0]     rd_ptr,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (commit) mem[wr_ptr] <= commit_data;
  end

  assign rd_data = mem[rd_ptr];

endmodule

// File: rtl/lw_pack_fifo.sv
module lw_pack_fifo
  import lwf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_size,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              flush,
  input  logic              pop,
  output logic [DATA_W-1:0] rd_data,
  output logic              full,
  output logic              empty,
  output logic              wr_err
);

  localparam int LANES = DATA_W / BYTE_W;
  localparam int LW    = $clog2(LANES);
  localparam int AW    = $clog2(DEPTH);

  logic [LW-1:0]     bptr, bptr_next;
  logic [LANES-1:0]  lane_we;
  logic [DATA_W-1:0] lane_data, commit_data;
  logic              aligned, wrap, commit;
  logic [AW-1:0]     wr_ptr, rd_ptr;
  wsize_e            size;

  assign size = wsize_e'(wr_size);

  lwf_lane_steer #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .LANES(LANES), .LW(LW)) u_steer (
    .bptr(bptr), .size(size), .din(wr_data), .lane_we(lane_we),
    .lane_data(lane_data), .aligned(aligned), .wrap(wrap), .bptr_next(bptr_next)
  );

  lwf_pack_stage #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .LANES(LANES), .LW(LW)) u_stage (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .flush(flush), .full(full),
    .lane_we(lane_we), .lane_data(lane_data), .aligned(aligned), .wrap(wrap),
    .bptr_next(bptr_next), .bptr(bptr), .commit(commit),
    .commit_data(commit_data), .wr_err(wr_err)
  );

  lwf_ptr_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .commit(commit), .pop(pop),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .full(full), .empty(empty)
  );

  lwf_entry_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .commit(commit), .wr_ptr(wr_ptr), .commit_data(commit_data),
    .rd_ptr(rd_ptr), .rd_data(rd_data)
  );

  AST_HEAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && !pop) |=> $stable(rd_data)); // R6
  AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty)); // R8

endmodule

// File: tb/lw_pack_fifo_bench.sv
module lw_pack_fifo_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, flush, pop;
  logic [1:0]  wr_size;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        full, empty, wr_err;

  always #4 clk = ~clk;

  lw_pack_fifo u_lw_pack_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_size(wr_size), .wr_data(wr_data),
    .flush(flush), .pop(pop), .rd_data(rd_data), .full(full), .empty(empty),
    .wr_err(wr_err)
  );

  int compared = 0, mismatched = 0;
  bit done = 0;
  string cur_tag = "R1";

  // reference model
  logic [31:0] m_q[$];
  logic [31:0] m_stage = '0;
  int          m_bptr  = 0;
  bit          m_err   = 0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(cur_tag, "empty", 32'(empty), 32'(m_q.size() == 0));
    chk(cur_tag, "full", 32'(full), 32'(m_q.size() == 8));
    chk(cur_tag, "wr_err", 32'(wr_err), 32'(m_err));
    if (m_q.size() != 0) chk(cur_tag, "rd_data", rd_data, m_q[0]);
  endtask

  task automatic step(bit we, bit [1:0] sz, bit [31:0] d, bit p, bit fl);
    int n;
    bit al, commit;
    logic [31:0] val, tmp;
    wr_en = we; wr_size = sz; wr_data = d; pop = p; flush = fl;
    n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : (sz == 2'd2) ? 4 : 0;
    al = (n != 0) && ((m_bptr % n) == 0);
    commit = 0; val = '0;
    @(posedge clk);
    #1;
    m_err = we && !fl && !al;
    if (fl) begin
      if (m_bptr != 0) begin commit = 1; val = m_stage; end
      m_stage = '0; m_bptr = 0;
    end else if (we && al && m_q.size() < 8) begin
      tmp = m_stage;
      for (int i = 0; i < n; i++) tmp[31 - 8*(m_bptr + i) -: 8] = d[8*(n - 1 - i) +: 8];
      if (m_bptr + n == 4) begin commit = 1; val = tmp; m_stage = '0; m_bptr = 0; end
      else begin m_stage = tmp; m_bptr = m_bptr + n; end
    end
    if (p && m_q.size() > 0) void'(m_q.pop_front());
    if (commit) m_q.push_back(val);
    compare_all();
  endtask

  task automatic idle(int cycles);
    for (int i = 0; i < cycles; i++) step(0, 2'd0, 32'h0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 0; wr_size = 0; wr_data = 0; pop = 0; flush = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "empty in reset", 32'(empty), 32'd1);
    chk("R1", "full in reset", 32'(full), 32'd0);
    chk("R1", "wr_err in reset", 32'(wr_err), 32'd0);
    rst_n = 1'b1;
    cur_tag = "R1"; idle(2);

    cur_tag = "R2";
    step(1, 2'd0, 32'h11, 0, 0); step(1, 2'd0, 32'h22, 0, 0);
    step(1, 2'd0, 32'h33, 0, 0);
    chk("R2", "not yet valid", 32'(empty), 32'd1);
    step(1, 2'd0, 32'h44, 0, 0);
    chk("R2", "byte entry", rd_data, 32'h11223344);

    cur_tag = "R3";
    step(1, 2'd1, 32'hAABB, 0, 0); step(1, 2'd1, 32'hCCDD, 0, 0);
    step(1, 2'd0, 32'h01, 0, 0); step(1, 2'd0, 32'h02, 0, 0);
    step(1, 2'd1, 32'h0304, 0, 0);

    cur_tag = "R4";
    step(1, 2'd2, 32'hDEADBEEF, 0, 0);

    cur_tag = "R6";
    step(0, 2'd0, 0, 1, 0);
    chk("R6", "head after pop", rd_data, 32'hAABBCCDD);
    step(0, 2'd0, 0, 1, 0);
    chk("R6", "mixed entry", rd_data, 32'h01020304);
    step(0, 2'd0, 0, 1, 0);
    chk("R4", "long entry", rd_data, 32'hDEADBEEF);
    step(0, 2'd0, 0, 1, 0);

    cur_tag = "R7";
    step(0, 2'd0, 0, 1, 0); step(0, 2'd0, 0, 1, 0);
    chk("R7", "still empty", 32'(empty), 32'd1);

    cur_tag = "R5";
    step(1, 2'd0, 32'h5A, 0, 0);
    step(1, 2'd1, 32'hFFFF, 0, 0);
    chk("R5", "err half@1", 32'(wr_err), 32'd1);
    step(1, 2'd2, 32'hFFFFFFFF, 0, 0);
    step(1, 2'd0, 32'h5B, 0, 0);
    chk("R5", "err clears", 32'(wr_err), 32'd0);
    step(1, 2'd0, 32'h5C, 0, 0);
    step(1, 2'd1, 32'hFFFF, 0, 0);
    step(1, 2'd2, 32'hFFFFFFFF, 0, 0);
    step(1, 2'd0, 32'h5D, 0, 0);
    chk("R5", "entry intact", rd_data, 32'h5A5B5C5D);
    step(1, 2'd3, 32'h12345678, 0, 0);
    step(0, 2'd0, 0, 1, 0);
    chk("R5", "reserved size dropped", 32'(empty), 32'd1);

    cur_tag = "R8";
    for (int i = 0; i < 8; i++) step(1, 2'd2, 32'h1000 + i, 0, 0);
    chk("R8", "full", 32'(full), 32'd1);
    step(1, 2'd2, 32'hBAD0BAD0, 0, 0);
    step(1, 2'd0, 32'hEE, 0, 0);
    step(0, 2'd0, 0, 1, 0);
    step(1, 2'd2, 32'h2000, 0, 0);
    for (int i = 0; i < 8; i++) step(0, 2'd0, 0, 1, 0);
    chk("R8", "drained", 32'(empty), 32'd1);

    cur_tag = "R9";
    step(1, 2'd0, 32'hA1, 0, 0); step(1, 2'd0, 32'hA2, 0, 0);
    step(1, 2'd0, 32'hA3, 0, 0);
    step(0, 2'd0, 0, 0, 1);
    chk("R9", "flush 3 lanes", rd_data, 32'hA1A2A300);
    step(0, 2'd0, 0, 0, 1);
    step(1, 2'd1, 32'hB1B2, 0, 0);
    step(1, 2'd0, 32'hC3, 0, 1);
    step(1, 2'd0, 32'hD1, 0, 1);
    step(1, 2'd1, 32'hE1E2, 0, 0); step(1, 2'd1, 32'hE3E4, 0, 0);
    step(0, 2'd0, 0, 1, 0);
    chk("R9", "half flush", rd_data, 32'hB1B20000);
    step(0, 2'd0, 0, 1, 0);
    chk("R9", "colliding write dropped", rd_data, 32'hE1E2E3E4);
    step(0, 2'd0, 0, 1, 0);

    cur_tag = "R10";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      step(r < 60, 2'($urandom_range(0, 3)), $urandom, $urandom_range(0, 99) < 35,
           $urandom_range(0, 99) < 4);
    end
    for (int i = 0; i < 10; i++) step(0, 2'd0, 0, 1, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule